// File: doc/BRIEF.md
# Stress-Measure Test Phase Sequencer

This block steps a degradation monitor through an accelerated test run. A run begins with a reference readout of the unstressed monitor. After that, stress phases and readout phases alternate. The stress phases get longer as the run goes on. The readout phases all have the same length. Before every readout there is a short settle gap with the supply at nominal level. A `meas_start` pulse then tells an external frequency counter to begin. The block counts pulses from a millisecond timebase for the stress and readout lengths. It counts clock cycles for the settle gap. The phases are shown on four outputs, which drive the bias supply switches and the heater enable.

There are two run modes. In aging mode, each stress phase drives the over-voltage bias. In annealing mode, each stress phase leaves the monitor unbiased and turns on only the heater. The readout that follows is taken back at nominal bias. Each mode has its own per-cycle duration table, and both tables are written through a small register port. At reset, the aging table holds a doubling series that starts at 60 ms. The annealing table holds the gaps of a 10 s / 30 s / 100 s … 10000 s cumulative schedule. The register port also sets the number of cycles and the mode. An abort input stops a run at any point.

Top module: `stress_meas_sequencer`

## Requirements
- R1: After reset, bias_stress, bias_nominal, heater_on, meas_start, busy and done are low and phase_idx is 0.
- R2: A start pulse from idle or done begins a run with a settle gap and then a measurement, before any stress phase. A run of N cycles contains exactly N+1 measurements.
- R3: Stress phase k (k counted from 0) lasts exactly table[k] timebase ticks of the active mode's table. A stored value of 0 acts as 1 tick.
- R4: Each measurement phase lasts MEAS_TICKS ticks with bias_nominal high. meas_start is a one-cycle pulse in its first cycle.
- R5: Each measurement is preceded by a settle gap of exactly SETTLE_CYC clock cycles. During the gap bias_nominal is high and meas_start is low. This includes the gap that directly follows each stress phase.
- R6: In annealing mode (mode bit 1), heater_on is high during the stress phases and bias_stress stays low. In aging mode (mode bit 0), bias_stress is high during the stress phases and heater_on stays low.
- R7: At most one of bias_stress, bias_nominal and heater_on is high in any cycle.
- R8: After the last measurement of a run, done is high, busy is low and phase_idx equals the cycle count. During stress phase k, phase_idx reads k+1. A cycle count written above MAX_CYC is stored as MAX_CYC, and a count of 0 runs only the reference measurement.
- R9: At reset, aging table entry k holds 60·2^k ticks. Annealing table entries 0..6 hold 10000, 20000, 70000, 200000, 700000, 2000000 and 7000000 ticks, and any later entries repeat the last value. The default cycle count is 10, clamped to MAX_CYC, and the default mode is aging.
- R10: An abort takes the block to idle on the next clock edge. After that edge all drive outputs, busy, done and phase_idx are 0, and a new start runs a full sequence.
- R11: While busy is high, a start pulse and any register write are ignored. The run goes on unchanged, and the tables and settings keep their earlier values.
- R12: Register address bits [5:4] select a bank and bits [3:0] select an entry. Bank 0 entry 0 is the mode (bit 0), bank 0 entry 1 is the cycle count, bank 1 is the aging duration table and bank 2 is the annealing duration table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse per millisecond of the timebase |
| start | input | 1 | Begin a run (taken only when not busy) |
| abort | input | 1 | Stop the run and return to idle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address: bank in [5:4], entry in [3:0] |
| cfg_wdata | input | 32 | Register write data |
| bias_stress | output | 1 | Connect the over-voltage stress supply |
| bias_nominal | output | 1 | Connect the nominal supply (settle and measurement) |
| heater_on | output | 1 | Enable the heater (annealing phases) |
| meas_start | output | 1 | One-cycle pulse that starts a frequency measurement |
| phase_idx | output | CNT_W | Number of stress phases begun in this run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run finished without abort |

## Verification
The bench goes after zero-length table entries. A design that loaded the raw zero would hang in that phase or skip it, and the measured tick count would come out wrong. It also writes cycle counts of zero and of more than the table depth: an off-by-one in the end test shows up as a missing or extra measurement, and a missing clamp would read past the table. It sends a start and a table write in the middle of a run, then reruns. A design that restarted or took the write would show a cut-short trace or a changed stress length on the rerun. Random tick gaps show whether the settle gap wrongly counts ticks instead of clock cycles, and whether the readout length drifts.

// File: rtl/seq_pkg.sv
// Package: shared state type, register map constants and the preload
// schedules for the stress-measure sequencer.
// Assumes DUR_W <= 32 at the users, since the preload functions return 32 bits.
package seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_MEAS,
        ST_STRESS,
        ST_DONE
    } seq_state_t;

    localparam int unsigned CFG_ADDR_W = 6;

    localparam logic [1:0] BANK_CTRL   = 2'd0;
    localparam logic [1:0] BANK_STRESS = 2'd1;
    localparam logic [1:0] BANK_ANNEAL = 2'd2;

    localparam logic [3:0] CTRL_MODE   = 4'd0;
    localparam logic [3:0] CTRL_CYCLES = 4'd1;

    localparam int unsigned DEFAULT_CYCLES = 10;

    // Aging preload: the first phase is 60 ticks and each later phase doubles.
    function automatic logic [31:0] stress_preload(input int unsigned idx);
        return 32'd60 << idx;
    endfunction

    // Anneal preload: gaps between the cumulative marks 10,30,...,10000 s, in ms.
    function automatic logic [31:0] anneal_preload(input int unsigned idx);
        case (idx)
            0:       return 32'd10000;
            1:       return 32'd20000;
            2:       return 32'd70000;
            3:       return 32'd200000;
            4:       return 32'd700000;
            5:       return 32'd2000000;
            default: return 32'd7000000;
        endcase
    endfunction

endpackage

// File: rtl/seq_cfg_regs.sv
// Configuration store: the run mode, the cycle count and two per-cycle
// duration tables, one per mode. Writes come in through a bank/entry address.
// Assumes MAX_CYC <= 16 (a 4-bit entry field) and that the caller gates
// wr_en while a run is active.
module seq_cfg_regs
    import seq_pkg::*;
#(
    parameter int unsigned MAX_CYC = 16,
    parameter int unsigned DUR_W   = 32,
    parameter int unsigned IDX_W   = 4,
    parameter int unsigned CNT_W   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CFG_ADDR_W-1:0] wr_addr,
    input  logic [31:0]           wr_data,
    input  logic                  rd_mode,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [DUR_W-1:0]      rd_dur,
    output logic                  mode_q,
    output logic [CNT_W-1:0]      cycles_q
);

    localparam int unsigned DEF_CYC =
        (DEFAULT_CYCLES > MAX_CYC) ? MAX_CYC : DEFAULT_CYCLES;

    logic [1:0]       wr_bank;
    logic [3:0]       wr_entry;
    logic [DUR_W-1:0] stress_tab [MAX_CYC];
    logic [DUR_W-1:0] anneal_tab [MAX_CYC];

    assign wr_bank  = wr_addr[5:4];
    assign wr_entry = wr_addr[3:0];

    // Control registers: the mode bit and the cycle count, clamped to the table depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            cycles_q <= CNT_W'(DEF_CYC);
        end else if (wr_en && wr_bank == BANK_CTRL) begin
            if (wr_entry == CTRL_MODE) begin
                mode_q <= wr_data[0];
            end
            if (wr_entry == CTRL_CYCLES) begin
                cycles_q <= (wr_data > 32'(MAX_CYC)) ? CNT_W'(MAX_CYC)
                                                     : wr_data[CNT_W-1:0];
            end
        end
    end

    for (genvar gi = 0; gi < MAX_CYC; gi++) begin : g_entry
        logic [DUR_W-1:0] stress_q;
        logic [DUR_W-1:0] anneal_q;

        // One table slot per mode: preloaded at reset, overwritten by an address match.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stress_q <= DUR_W'(stress_preload(gi));
                anneal_q <= DUR_W'(anneal_preload(gi));
            end else if (wr_en && wr_entry == 4'(gi)) begin
                if (wr_bank == BANK_STRESS) begin
                    stress_q <= wr_data[DUR_W-1:0];
                end
                if (wr_bank == BANK_ANNEAL) begin
                    anneal_q <= wr_data[DUR_W-1:0];
                end
            end
        end

        assign stress_tab[gi] = stress_q;
        assign anneal_tab[gi] = anneal_q;
    end

    assign rd_dur = rd_mode ? anneal_tab[rd_idx] : stress_tab[rd_idx];

endmodule

// File: rtl/seq_phase_timer.sv
// Down-counting phase timer. A load sets the phase length (a zero counts as
// one), and each step removes one unit. expire marks the step that uses up
// the last unit, so a phase loaded with L lasts exactly L steps.
// Assumes load and step never refer to the same phase in one cycle.
module seq_phase_timer #(
    parameter int unsigned DUR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DUR_W-1:0] load_val,
    input  logic             step,
    output logic             expire
);

    logic [DUR_W-1:0] cnt_q;

    // Remaining units of the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? DUR_W'(1) : load_val;
        end else if (step && cnt_q != '0) begin
            cnt_q <= cnt_q - DUR_W'(1);
        end
    end

    assign expire = step && (cnt_q == DUR_W'(1));

endmodule

// File: rtl/seq_ctrl.sv
// Sequencing FSM. It runs: settle, reference measurement, then per cycle
// stress (or anneal), settle and measurement, and finally done. Stress and
// measurement count timebase ticks. Settle counts clock cycles. The mode and
// the cycle count are latched at start, so the run does not depend on later
// register changes.
// Assumes cfg_cycles <= MAX_CYC (the config store clamps it).
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int unsigned MAX_CYC    = 16,
    parameter int unsigned DUR_W      = 32,
    parameter int unsigned IDX_W      = 4,
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned SETTLE_CYC = 5000,
    parameter int unsigned MEAS_TICKS = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             abort,
    input  logic             cfg_mode,
    input  logic [CNT_W-1:0] cfg_cycles,
    input  logic [DUR_W-1:0] rd_dur,
    input  logic             expire,
    output logic             rd_mode,
    output logic [IDX_W-1:0] rd_idx,
    output logic             load,
    output logic [DUR_W-1:0] load_val,
    output logic             step,
    output logic             bias_stress,
    output logic             bias_nominal,
    output logic             heater_on,
    output logic             meas_start,
    output logic [CNT_W-1:0] phase_idx,
    output logic             busy,
    output logic             done
);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cyc_q, cyc_d;
    logic [CNT_W-1:0] ncyc_q;
    logic             mode_q;
    logic             meas_q, meas_d;
    logic             can_start;

    assign can_start = (state_q == ST_IDLE || state_q == ST_DONE) && start;

    // Next state, the timer load and the next cycle index; abort overrides all.
    always_comb begin
        state_d  = state_q;
        cyc_d    = cyc_q;
        load     = 1'b0;
        load_val = '0;
        meas_d   = 1'b0;
        case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d  = ST_SETTLE;
                    cyc_d    = '0;
                    load     = 1'b1;
                    load_val = DUR_W'(SETTLE_CYC);
                end
            end
            ST_SETTLE: begin
                if (expire) begin
                    state_d  = ST_MEAS;
                    load     = 1'b1;
                    load_val = DUR_W'(MEAS_TICKS);
                    meas_d   = 1'b1;
                end
            end
            ST_MEAS: begin
                if (expire) begin
                    if (cyc_q == ncyc_q) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_STRESS;
                        cyc_d    = cyc_q + CNT_W'(1);
                        load     = 1'b1;
                        load_val = rd_dur;
                    end
                end
            end
            ST_STRESS: begin
                if (expire) begin
                    state_d  = ST_SETTLE;
                    load     = 1'b1;
                    load_val = DUR_W'(SETTLE_CYC);
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
            cyc_d   = '0;
            load    = 1'b0;
            meas_d  = 1'b0;
        end
    end

    // State, cycle index and the registered measurement strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
            meas_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cyc_q   <= cyc_d;
            meas_q  <= meas_d;
        end
    end

    // Run settings, captured when a run is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ncyc_q <= '0;
            mode_q <= 1'b0;
        end else if (can_start && !abort) begin
            ncyc_q <= cfg_cycles;
            mode_q <= cfg_mode;
        end
    end

    assign rd_mode = mode_q;
    assign rd_idx  = cyc_q[IDX_W-1:0];

    // Timer step source: clock cycles during settle, ticks during the timed phases.
    always_comb begin
        case (state_q)
            ST_SETTLE:          step = 1'b1;
            ST_MEAS, ST_STRESS: step = tick;
            default:            step = 1'b0;
        endcase
    end

    assign bias_stress  = (state_q == ST_STRESS) && !mode_q;
    assign heater_on    = (state_q == ST_STRESS) && mode_q;
    assign bias_nominal = (state_q == ST_SETTLE) || (state_q == ST_MEAS);
    assign meas_start   = meas_q;
    assign phase_idx    = cyc_q;
    assign busy         = (state_q == ST_SETTLE) || (state_q == ST_MEAS) ||
                          (state_q == ST_STRESS);
    assign done         = (state_q == ST_DONE);

endmodule

// File: rtl/stress_meas_sequencer.sv
// Top: stress-measure test phase sequencer. It ties together the config
// store, the phase timer and the sequencing FSM. Register writes are blocked
// while a run is active.
// Assumes tick is a one-cycle pulse synchronous to clk and MAX_CYC <= 16.
module stress_meas_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned MAX_CYC    = 16,
    parameter int unsigned DUR_W      = 32,
    parameter int unsigned SETTLE_CYC = 5000,
    parameter int unsigned MEAS_TICKS = 100000,
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             abort,
    input  logic             cfg_we,
    input  logic [5:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic             bias_stress,
    output logic             bias_nominal,
    output logic             heater_on,
    output logic             meas_start,
    output logic [CNT_W-1:0] phase_idx,
    output logic             busy,
    output logic             done
);

    localparam int unsigned IDX_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic             cfg_mode;
    logic [CNT_W-1:0] cfg_cycles;
    logic             rd_mode;
    logic [IDX_W-1:0] rd_idx;
    logic [DUR_W-1:0] rd_dur;
    logic             tmr_load;
    logic [DUR_W-1:0] tmr_val;
    logic             tmr_step;
    logic             tmr_expire;
    logic             wr_en;

    assign wr_en = cfg_we && !busy;

    seq_cfg_regs #(
        .MAX_CYC (MAX_CYC),
        .DUR_W   (DUR_W),
        .IDX_W   (IDX_W),
        .CNT_W   (CNT_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .rd_mode  (rd_mode),
        .rd_idx   (rd_idx),
        .rd_dur   (rd_dur),
        .mode_q   (cfg_mode),
        .cycles_q (cfg_cycles)
    );

    seq_phase_timer #(
        .DUR_W (DUR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .step     (tmr_step),
        .expire   (tmr_expire)
    );

    seq_ctrl #(
        .MAX_CYC    (MAX_CYC),
        .DUR_W      (DUR_W),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W),
        .SETTLE_CYC (SETTLE_CYC),
        .MEAS_TICKS (MEAS_TICKS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .start        (start),
        .abort        (abort),
        .cfg_mode     (cfg_mode),
        .cfg_cycles   (cfg_cycles),
        .rd_dur       (rd_dur),
        .expire       (tmr_expire),
        .rd_mode      (rd_mode),
        .rd_idx       (rd_idx),
        .load         (tmr_load),
        .load_val     (tmr_val),
        .step         (tmr_step),
        .bias_stress  (bias_stress),
        .bias_nominal (bias_nominal),
        .heater_on    (heater_on),
        .meas_start   (meas_start),
        .phase_idx    (phase_idx),
        .busy         (busy),
        .done         (done)
    );

endmodule

// File: rtl/stress_meas_sequencer_chk.sv
// Checker for the sequencer's port-level timing rules. It is bound to every
// instance of the top module.
module stress_meas_sequencer_chk #(
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             abort,
    input logic             bias_stress,
    input logic             bias_nominal,
    input logic             heater_on,
    input logic             meas_start,
    input logic [CNT_W-1:0] phase_idx,
    input logic             busy,
    input logic             done
);

    // R7: the supply and heater drives never overlap.
    p_onehot_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bias_stress, bias_nominal, heater_on}));

    // R10: an abort leaves everything quiet on the next cycle.
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!bias_stress && !bias_nominal && !heater_on && !busy && !done));

    // R4: the measurement strobe lasts one cycle.
    p_meas_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |=> !meas_start);

    // R4: the strobe only occurs with the nominal supply connected.
    p_meas_nominal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        meas_start |-> bias_nominal);

    // R5: the end of a stress phase is followed by a settle gap, not by a strobe.
    p_settle_after_stress_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bias_stress) && !$past(abort)) |-> (bias_nominal && !meas_start));

    // R8: during a run the phase index holds or advances by one.
    p_idx_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort) |=> ((phase_idx == $past(phase_idx)) ||
                              (phase_idx == $past(phase_idx) + CNT_W'(1))));

endmodule

bind stress_meas_sequencer stress_meas_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort        (abort),
    .bias_stress  (bias_stress),
    .bias_nominal (bias_nominal),
    .heater_on    (heater_on),
    .meas_start   (meas_start),
    .phase_idx    (phase_idx),
    .busy         (busy),
    .done         (done)
);

// File: tb/stress_meas_sequencer_bench.sv
module stress_meas_sequencer_bench;

    localparam int MAXC   = 8;
    localparam int SETTLE = 5;
    localparam int MEAS   = 20;
    localparam int CW     = $clog2(MAXC + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          bias_stress, bias_nominal, heater_on, meas_start, busy, done;
    logic [CW-1:0] phase_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int exp_dur [MAXC];

    always #10 clk = ~clk;

    stress_meas_sequencer #(
        .MAX_CYC    (MAXC),
        .DUR_W      (32),
        .SETTLE_CYC (SETTLE),
        .MEAS_TICKS (MEAS)
    ) u_stress_meas_sequencer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .abort(abort),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .bias_stress(bias_stress), .bias_nominal(bias_nominal),
        .heater_on(heater_on), .meas_start(meas_start),
        .phase_idx(phase_idx), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] bank, input int entry, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {bank, 4'(entry)};
        cfg_wdata = 32'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Runs one sequence, rebuilds the trace from the ports and compares it with the expectation.
    task automatic run_seq(input int m, input int n, input int pct, input bit poke,
                           input string dreq);
        int st_len [MAXC];
        int st_cnt = 0, meas_cnt = 0, settle = 0, mt = 0, cyc = 0;
        int excl_bad = 0, mode_bad = 0, idx_bad = 0, settle_bad = 0, mt_bad = 0;
        bit in_nom = 0, seen = 0, prev_act = 0, fresh_ok = 0, act = 0, t = 0;
        foreach (st_len[i]) st_len[i] = 0;
        @(negedge clk);
        start = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            start  = 1'b0;
            cfg_we = 1'b0;
            if (poke && cyc == 3) begin
                start     = 1'b1;
                cfg_we    = 1'b1;
                cfg_addr  = {2'd1, 4'd0};
                cfg_wdata = 32'd999;
            end
            t = ($urandom_range(0, 99) < pct);
            tick = t;
            act = bias_stress | heater_on;
            if ($countones({bias_stress, bias_nominal, heater_on}) > 1) excl_bad++;
            if (meas_start && !bias_nominal) mt_bad++;
            if (act) begin
                if (!prev_act) begin
                    st_cnt++;
                    if (int'(phase_idx) != st_cnt) idx_bad++;
                end
                if (st_cnt > 0 && st_cnt <= MAXC) st_len[st_cnt-1] += int'(t);
                if (m != 0 ? (bias_stress || !heater_on) : (heater_on || !bias_stress))
                    mode_bad++;
            end
            prev_act = act;
            if (bias_nominal) begin
                if (!in_nom) begin
                    in_nom = 1; seen = 0; settle = 0; mt = 0;
                end
                if (meas_start) begin
                    seen = 1;
                    meas_cnt++;
                    if (meas_cnt == 1 && st_cnt == 0) fresh_ok = 1;
                end
                if (!seen) settle++;
                else mt += int'(t);
            end else if (in_nom) begin
                in_nom = 0;
                if (settle != SETTLE) settle_bad++;
                if (mt != MEAS) mt_bad++;
            end
            if (done) break;
            if (cyc > 120000) begin
                chk(0, "R8", "run did not finish", cyc, 0);
                break;
            end
        end
        tick = 1'b0;
        chk(fresh_ok, "R2", "reference measurement before stress", int'(fresh_ok), 1);
        chk(meas_cnt == n + 1, "R2", "measurement count", meas_cnt, n + 1);
        chk(st_cnt == n, "R8", "stress phase count", st_cnt, n);
        for (int k = 0; k < n && k < MAXC; k++)
            chk(st_len[k] == eff(exp_dur[k]), dreq, $sformatf("stress phase %0d ticks", k),
                st_len[k], eff(exp_dur[k]));
        chk(settle_bad == 0, "R5", "bad settle gaps", settle_bad, 0);
        chk(mt_bad == 0, "R4", "bad measurement windows", mt_bad, 0);
        chk(excl_bad == 0, "R7", "overlapping drive cycles", excl_bad, 0);
        chk(mode_bad == 0, "R6", "wrong drive for mode", mode_bad, 0);
        chk(idx_bad == 0, "R8", "phase_idx mismatches", idx_bad, 0);
        chk(int'(phase_idx) == n && !busy, "R8", "final phase_idx", int'(phase_idx), n);
    endtask

    initial begin
        int m, n, ne, pct, v, w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!bias_stress && !bias_nominal && !heater_on && !meas_start && !busy && !done &&
            phase_idx == 0, "R1", "outputs after reset",
            int'({bias_stress, bias_nominal, heater_on, meas_start, busy, done}), 0);

        // R9 aging preload, R12 cycle count register
        cfg_write(2'd0, 1, 3);
        exp_dur[0] = 60; exp_dur[1] = 120; exp_dur[2] = 240;
        run_seq(0, 3, 100, 0, "R9");

        // R9 anneal preload, R6 heater-only phases
        cfg_write(2'd0, 0, 1);
        cfg_write(2'd0, 1, 2);
        exp_dur[0] = 10000; exp_dur[1] = 20000;
        run_seq(1, 2, 100, 0, "R9");

        // R3 zero and one tick entries, with full and gappy ticks
        cfg_write(2'd0, 0, 0);
        cfg_write(2'd1, 0, 0);
        cfg_write(2'd1, 1, 1);
        cfg_write(2'd1, 2, 7);
        cfg_write(2'd0, 1, 3);
        exp_dur[0] = 0; exp_dur[1] = 1; exp_dur[2] = 7;
        run_seq(0, 3, 100, 0, "R3");
        run_seq(0, 3, 40, 0, "R3");

        // R8 zero cycles: reference readout only
        cfg_write(2'd0, 1, 0);
        run_seq(0, 0, 100, 0, "R8");

        // R8 clamp of an oversized cycle count
        for (int k = 0; k < MAXC; k++) begin
            cfg_write(2'd1, k, k + 2);
            exp_dur[k] = k + 2;
        end
        cfg_write(2'd0, 1, 31);
        run_seq(0, MAXC, 100, 0, "R8");

        // R12 anneal bank writes
        for (int k = 0; k < MAXC; k++) begin
            cfg_write(2'd2, k, 3 * k);
            exp_dur[k] = 3 * k;
        end
        cfg_write(2'd0, 0, 1);
        run_seq(1, MAXC, 70, 0, "R12");

        // R11 start and table write during a run are ignored
        cfg_write(2'd0, 0, 0);
        cfg_write(2'd0, 1, 1);
        cfg_write(2'd1, 0, 4);
        exp_dur[0] = 4;
        run_seq(0, 1, 100, 1, "R11");
        run_seq(0, 1, 100, 0, "R11");

        // R10 abort during a stress phase
        @(negedge clk);
        start = 1'b1;
        tick  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        v = 0;
        while (!bias_stress && v < 200) begin
            @(negedge clk);
            v++;
        end
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        tick  = 1'b0;
        chk(!bias_stress && !bias_nominal && !heater_on && !busy && !done && phase_idx == 0,
            "R10", "outputs after abort",
            int'({bias_stress, bias_nominal, heater_on, busy, done}), 0);
        run_seq(0, 1, 100, 0, "R10");

        // Random runs: R3 durations from the written tables
        for (int r = 0; r < 6; r++) begin
            m   = $urandom_range(0, 1);
            n   = $urandom_range(0, MAXC + 3);
            ne  = (n > MAXC) ? MAXC : n;
            pct = $urandom_range(30, 100);
            cfg_write(2'd0, 0, m);
            cfg_write(2'd0, 1, n);
            for (int k = 0; k < MAXC; k++) begin
                w = $urandom_range(0, 15);
                cfg_write((m != 0) ? 2'd2 : 2'd1, k, w);
                exp_dur[k] = w;
            end
            run_seq(m, ne, pct, 0, "R3");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule